// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a sum-of-products logic array. Each cell takes one OR-sum from the array and one output-enable product term. It drives one bidirectional pin, which is modelled as separate out, enable and in signals. It also returns one feedback signal to the array.

Every cell has a two-bit mode. One bit selects whether the pin shows a D flip-flop's state or the live sum. The other bit selects the pin polarity. The flip-flop always stores the true, uninverted sum. Inversion is applied after it.

All cells share one clock, one synchronous preset and one asynchronous clear. The clear is the OR of a product term and a power-up reset input. It acts at once. Its release passes through a short synchronizer, so the registers resume loading only on a known clock edge.

Feedback depends on the mode. A registered cell returns its flip-flop state. A combinatorial cell returns the pin level: its own driven value while enabled, or the externally applied value while disabled.

Top module: `mc_output_bank`

## Requirements
- R1: Mode bit 1 of a cell selects combinatorial operation when 1 and registered operation when 0. Mode bit 0 selects active-high when 1 and active-low when 0, so codes 00, 01, 10 and 11 are registered-low, registered-high, combinatorial-low and combinatorial-high.
- R2: In registered mode the flip-flop loads the true sum on each rising clock edge. The pin shows that state, inverted when the cell is active-low.
- R3: In combinatorial mode the pin follows the sum in the same cycle, inverted when the cell is active-low.
- R4: In registered mode the feedback equals the flip-flop's true state, whatever the output enable.
- R5: In combinatorial mode the feedback equals the cell's driven pin value while enabled. It equals the external pin input while disabled.
- R6: Each cell's pin enable output equals its own output-enable product term in the same cycle.
- R7: A high clear term or a low power-up reset forces every flip-flop to 0 at once, without waiting for a clock edge.
- R8: After the clear is removed, the flip-flops hold 0 for SYNC_STAGES rising edges (default 2). They first load on the next edge after that.
- R9: When the shared preset is high at a rising edge, every flip-flop becomes 1, whatever the sum. The clear overrides the preset.
- R10: After a power-up reset, registered active-low pins read 1 and registered active-high pins read 0, under all four mode codes.
- R11: A cell's mode, sum, enable and pin input affect only that cell's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| arst_i | input | 1 | Shared asynchronous clear product term, active high |
| spreset_i | input | 1 | Shared synchronous preset product term, active high |
| cfg_i | input | NCELL x 2 | Per-cell mode: bit 1 combinatorial, bit 0 active-high |
| sum_i | input | NCELL | OR-sum from the array, one per cell |
| oe_term_i | input | NCELL | Output-enable product term, one per cell |
| pin_in_i | input | NCELL | Level applied to each pin from outside |
| pin_out_o | output | NCELL | Value driven toward each pin |
| pin_oe_o | output | NCELL | Pin drive enable |
| fb_o | output | NCELL | Feedback returned to the array |

## Verification
The preset can fall in the same cycle as the sum load and in the same cycle as the clear. The bench raises the preset while every sum is 0, which must yield all ones. It also raises the clear and the preset together in one cycle. The pins are sampled a moment after the clear rises, to confirm the immediate clear, and again at the next edge, to confirm the clear wins over the preset. A behavioural model with a release counter predicts every output on every cycle across all four mode codes.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } mc_mode_e;

  typedef struct packed {
    logic comb;
    logic act_high;
  } mc_ctl_t;

  function automatic mc_ctl_t mc_decode(input logic [1:0] code);
    mc_ctl_t c;
    c.comb     = code[1];
    c.act_high = code[0];
    return c;
  endfunction

endpackage

// File: rtl/mc_reset_sync.sv
module mc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic raw_rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge raw_rst_n) begin
    if (!raw_rst_n) chain_q <= '0;
    else            chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    if (preset) q_nxt = '1;
    else        q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R9: preset sets every bit on the following edge
  a_r9_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> q == '1);

  // R2: without preset the true sum is captured
  a_r2_loads_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !preset |=> q == $past(d));

  // R7: while clear is active the state is zero
  always @(negedge clk) begin
    if (!rst_n) a_r7_cleared: assert (q == '0) else $error("R7 state not cleared");
  end

endmodule

// File: rtl/mc_cell_path.sv
module mc_cell_path
  import mc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sum,
  input  logic       reg_q,
  input  logic       oe_term,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb
);

  mc_ctl_t ctl;
  logic    sel_val;
  logic    pin_level;

  always_comb begin
    ctl       = mc_decode(mode);
    sel_val   = ctl.comb ? sum : reg_q;
    pin_out   = ctl.act_high ? sel_val : ~sel_val;
    pin_oe    = oe_term;
    pin_level = oe_term ? pin_out : pin_in;
    fb        = ctl.comb ? pin_level : reg_q;
  end

endmodule

// File: rtl/mc_output_bank.sv
module mc_output_bank
  import mc_pkg::*;
#(
  parameter int NCELL       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  arst_i,
  input  logic                  spreset_i,
  input  logic [NCELL-1:0][1:0] cfg_i,
  input  logic [NCELL-1:0]      sum_i,
  input  logic [NCELL-1:0]      oe_term_i,
  input  logic [NCELL-1:0]      pin_in_i,
  output logic [NCELL-1:0]      pin_out_o,
  output logic [NCELL-1:0]      pin_oe_o,
  output logic [NCELL-1:0]      fb_o
);

  localparam int SYNC_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic             raw_rst_n;
  logic             rst_q_n;
  logic [NCELL-1:0] reg_q;

  assign raw_rst_n = por_n & ~arst_i;

  mc_reset_sync #(.STAGES(SYNC_W)) u_sync (
    .clk       (clk),
    .raw_rst_n (raw_rst_n),
    .rst_q_n   (rst_q_n)
  );

  mc_state_reg #(.W(NCELL)) u_state (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .preset (spreset_i),
    .d      (sum_i),
    .q      (reg_q)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    mc_cell_path u_path (
      .mode    (cfg_i[g]),
      .sum     (sum_i[g]),
      .reg_q   (reg_q[g]),
      .oe_term (oe_term_i[g]),
      .pin_in  (pin_in_i[g]),
      .pin_out (pin_out_o[g]),
      .pin_oe  (pin_oe_o[g]),
      .fb      (fb_o[g])
    );

    // R5: a disabled combinatorial cell returns the external level
    a_r5_fb_external: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cfg_i[g][1] && !oe_term_i[g]) |-> fb_o[g] == pin_in_i[g]);

    // R5: an enabled combinatorial cell returns its own drive
    a_r5_fb_driven: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cfg_i[g][1] && oe_term_i[g]) |-> fb_o[g] == pin_out_o[g]);

    // R3: combinatorial active-high pin tracks the sum
    a_r3_comb_follow: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cfg_i[g] == MODE_COMB_HIGH) |-> pin_out_o[g] == sum_i[g]);

    // R4: registered feedback is the stored state, inverse of an active-low pin
    a_r4_fb_state: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cfg_i[g] == MODE_REG_LOW) |-> fb_o[g] == ~pin_out_o[g]);
  end

endmodule

// File: tb/mc_output_bank_bench.sv
module mc_output_bank_bench;

  localparam int N = 10;
  localparam int S = 2;

  logic                clk;
  logic                por_n;
  logic                arst_i;
  logic                spreset_i;
  logic [N-1:0][1:0]   cfg_i;
  logic [N-1:0]        sum_i;
  logic [N-1:0]        oe_term_i;
  logic [N-1:0]        pin_in_i;
  logic [N-1:0]        pin_out_o;
  logic [N-1:0]        pin_oe_o;
  logic [N-1:0]        fb_o;

  int checks = 0;
  int errors = 0;

  mc_output_bank #(.NCELL(N), .SYNC_STAGES(S)) u_mc_output_bank (
    .clk       (clk),
    .por_n     (por_n),
    .arst_i    (arst_i),
    .spreset_i (spreset_i),
    .cfg_i     (cfg_i),
    .sum_i     (sum_i),
    .oe_term_i (oe_term_i),
    .pin_in_i  (pin_in_i),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o),
    .fb_o      (fb_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural model: stored state plus a count of edges since release
  logic         m_rst;
  logic [N-1:0] m_reg;
  int           m_cnt;

  assign m_rst = arst_i | ~por_n;

  always @(posedge clk or posedge m_rst) begin
    if (m_rst) begin
      m_reg <= '0;
      m_cnt <= 0;
    end else if (m_cnt >= S) begin
      m_reg <= spreset_i ? {N{1'b1}} : sum_i;
    end else begin
      m_cnt <= m_cnt + 1;
    end
  end

  task automatic check_all(input string tag);
    logic [N-1:0] e_out, e_oe, e_fb, st;
    st = m_rst ? '0 : m_reg;
    for (int i = 0; i < N; i++) begin
      logic v;
      v        = cfg_i[i][1] ? sum_i[i] : st[i];
      e_out[i] = cfg_i[i][0] ? v : ~v;
      e_oe[i]  = oe_term_i[i];
      e_fb[i]  = cfg_i[i][1] ? (oe_term_i[i] ? e_out[i] : pin_in_i[i]) : st[i];
    end
    checks++;
    if (pin_out_o !== e_out || pin_oe_o !== e_oe || fb_o !== e_fb) begin
      errors++;
      $display("FAIL %s: out=%h exp %h, oe=%h exp %h, fb=%h exp %h",
               tag, pin_out_o, e_out, pin_oe_o, e_oe, fb_o, e_fb);
    end
  endtask

  task automatic shuffle();
    sum_i     = N'($urandom);
    oe_term_i = N'($urandom);
    pin_in_i  = N'($urandom);
  endtask

  task automatic run_random(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all(tag);
      shuffle();
      spreset_i = ($urandom % 8) == 0;
    end
  endtask

  task automatic set_all_modes(input logic [1:0] code);
    for (int i = 0; i < N; i++) cfg_i[i] = code;
  endtask

  initial begin
    por_n = 1'b0; arst_i = 1'b0; spreset_i = 1'b0;
    for (int i = 0; i < N; i++) cfg_i[i] = 2'(i % 4);
    shuffle();
    repeat (2) @(negedge clk);
    // R10 and R1: mixed codes, power-up levels
    check_all("R10 power-up level mixed codes R1");
    #1 check_all("R10 power-up level mid-cycle");

    // R8: release, sums all ones, count edges to first load
    @(negedge clk);
    por_n = 1'b1; sum_i = '1; oe_term_i = '1;
    for (int k = 0; k < S + 2; k++) begin
      @(negedge clk);
      check_all("R8 release delay");
    end

    // R2 R3 R4 R5 R6 R11: random traffic over mixed codes
    run_random(150, "R2 R3 R4 R5 R6 R11 mixed traffic");

    // R9: preset with every sum at zero
    @(negedge clk);
    spreset_i = 1'b1; sum_i = '0;
    @(negedge clk);
    check_all("R9 preset over zero sum");
    spreset_i = 1'b0;
    @(negedge clk);
    check_all("R2 load after preset");

    // R7 and R9: clear and preset raised in the same cycle
    spreset_i = 1'b1; sum_i = '1; arst_i = 1'b1;
    #1 check_all("R7 immediate clear");
    @(negedge clk);
    check_all("R9 clear wins over preset");
    arst_i = 1'b0; spreset_i = 1'b0;
    for (int k = 0; k < S + 2; k++) begin
      @(negedge clk);
      check_all("R8 release after clear term");
    end

    // R1 R10 per code: each code on every cell, power-up pulse, traffic
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      set_all_modes(2'(c));
      por_n = 1'b0;
      #1 check_all("R10 power-up per code R1");
      @(negedge clk);
      check_all("R10 held in power-up");
      por_n = 1'b1;
      run_random(40, "R1 R2 R3 R4 R5 per code");
    end

    // R11: alternate codes on neighbours
    for (int i = 0; i < N; i++) cfg_i[i] = (i % 2) ? 2'b10 : 2'b01;
    run_random(40, "R11 neighbour isolation");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(2_000_000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule